// File: doc/BRIEF.md
# Smart Card Contact Supervisor

This block sits between the reader's control logic and the contact pins of a smart card. It brings the asynchronous card-presence input into the clock domain. It reports every insertion or removal through a sticky status flag and a maskable interrupt. It also decides whether the clock, data and supply contacts are live or held inactive.

A single power-down control gates the contacts. Software sets and clears it. Hardware also sets it as soon as removal is seen. The supply enable pin can be asserted high or asserted low to suit the external power switch. The supply class selection can only be changed while the contacts are powered down. The card reset contact is left under direct software control whatever the power-down state.

Software reaches the block through a small register port with a write strobe, an address and a combinational read-back.

Top module: `sc_contact_ctrl`

## Requirements
- R1: `card_present_i` passes through two synchronizing flops. A presence change driven before clock edge N sets the toggle flag (STATUS bit 0, address 1) at edge N+2. Each transition gives exactly one event, for rising and falling edges alike.
- R2: The toggle flag stays set until software writes 1 to STATUS bit 0. Writing 0 there leaves the flag unchanged. A new event in the same cycle as the clear wins.
- R3: `irq_o` is 1 exactly when the toggle flag and the interrupt enable (CTRL bit 3, address 0) are both 1.
- R4: While power-down (CTRL bit 0) is 1, `card_clk_o` and `card_io_o` are driven 0 and the supply is off, from the cycle after it is seen. `card_rst_o` follows CTRL bit 4, one cycle late, whatever the power-down state.
- R5: When the synchronized presence falls (card removed), power-down becomes 1 at the following edge without any write.
- R6: A CTRL write of power-down 0 while the synchronized presence is 0 leaves power-down at 1.
- R7: CTRL bit 1 selects the supply polarity. The supply is on when supply-request (CTRL bit 2) is 1 and power-down is 0. `card_vcc_o` is registered and equals that on-state when polarity is 1, and its inverse when polarity is 0. A polarity change shows on the pin one cycle after the write.
- R8: The supply class field (CTRL bits 6:5, output `card_class_o`) takes the written value only when power-down was already 1 before the write. Otherwise the field keeps its value.
- R9: Reset sets power-down to 1 and clears polarity, supply-request, enable, reset level, class and the flag. It leaves `card_vcc_o` at 1 and `irq_o` at 0.
- R10: Reading address 0 returns all CTRL fields at their bit positions. Address 1 returns the flag in bit 0 and the synchronized presence in bit 1. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for write and read |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data |
| card_present_i | input | 1 | Debounced card presence, asynchronous |
| clk_src_i | input | 1 | Card clock from the divider |
| io_src_i | input | 1 | Serial data from the transceiver |
| card_clk_o | output | 1 | Card clock contact |
| card_io_o | output | 1 | Card data contact |
| card_vcc_o | output | 1 | Supply switch control, polarity selected |
| card_rst_o | output | 1 | Card reset contact |
| card_class_o | output | CLASS_W | Supply class select for the generator |
| irq_o | output | 1 | Presence-toggle interrupt |

## Verification
A bad power-down state shows within one cycle as a live clock or data contact on an absent card, or as a supply pin that does not follow the polarity bit. A lost or doubled presence event shows two edges after the input change, as a wrong toggle flag and interrupt. A class update that leaks through while powered up is visible at once on `card_class_o`. The bench predicts every output each clock from a behavioural model and compares them all, so any divergence is reported in the cycle it occurs.

// File: rtl/sc_contact_pkg.sv
package sc_contact_pkg;
   localparam int unsigned CTRL_ADDR = 0;
   localparam int unsigned STAT_ADDR = 1;

   localparam int unsigned B_PD   = 0;
   localparam int unsigned B_POL  = 1;
   localparam int unsigned B_REQ  = 2;
   localparam int unsigned B_IE   = 3;
   localparam int unsigned B_RST  = 4;
   localparam int unsigned B_CLS  = 5;

   localparam int unsigned B_FLAG = 0;
   localparam int unsigned B_PRES = 1;

   typedef struct packed {
      logic rst_lvl;
      logic ie;
      logic req;
      logic pol;
      logic pd;
   } ctl_flags_t;
endpackage

// File: rtl/sc_presence_sync.sv
module sc_presence_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic present_o,
   output logic evt_o,
   output logic fall_o
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   initial assert (STAGES >= 2) else $error("sync chain needs at least two stages");

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[0], raw_i};
         end
      end else begin : g_long
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], raw_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sh_q[STAGES-1];
   end

   assign present_o = sh_q[STAGES-1];
   assign evt_o     = sh_q[STAGES-1] ^ prev_q;
   assign fall_o    = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/sc_ctl_regs.sv
module sc_ctl_regs
   import sc_contact_pkg::*;
#(
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CLASS_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic                present_i,
   input  logic                evt_i,
   input  logic                fall_i,
   output ctl_flags_t          flags_o,
   output logic [CLASS_W-1:0]  cls_o,
   output logic                flag_o,
   output logic [DATA_W-1:0]   rdata_o
);
   localparam int unsigned CTRL_BITS = B_CLS + CLASS_W;

   initial assert (CTRL_BITS <= DATA_W) else $error("data width too small for control fields");
   initial assert (ADDR_W >= 1) else $error("address width must be at least 1");

   ctl_flags_t         flags_q;
   logic [CLASS_W-1:0] cls_q;
   logic               flag_q;
   logic               wr_ctrl, wr_stat;

   assign wr_ctrl = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));
   assign wr_stat = wr_i && (addr_i == ADDR_W'(STAT_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '{pd: 1'b1, default: 1'b0};
         cls_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            flags_q.pol     <= wdata_i[B_POL];
            flags_q.req     <= wdata_i[B_REQ];
            flags_q.ie      <= wdata_i[B_IE];
            flags_q.rst_lvl <= wdata_i[B_RST];
            flags_q.pd      <= wdata_i[B_PD] | ~present_i | fall_i;
            if (flags_q.pd) cls_q <= wdata_i[B_CLS +: CLASS_W];
         end else if (fall_i) begin
            flags_q.pd <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= 1'b0;
      else if (evt_i)                      flag_q <= 1'b1;
      else if (wr_stat && wdata_i[B_FLAG]) flag_q <= 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(CTRL_ADDR)) begin
         rdata_o[B_PD]  = flags_q.pd;
         rdata_o[B_POL] = flags_q.pol;
         rdata_o[B_REQ] = flags_q.req;
         rdata_o[B_IE]  = flags_q.ie;
         rdata_o[B_RST] = flags_q.rst_lvl;
         rdata_o[B_CLS +: CLASS_W] = cls_q;
      end else if (addr_i == ADDR_W'(STAT_ADDR)) begin
         rdata_o[B_FLAG] = flag_q;
         rdata_o[B_PRES] = present_i;
      end
   end

   assign flags_o = flags_q;
   assign cls_o   = cls_q;
   assign flag_o  = flag_q;

   // R1
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_q);
   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_stat && wdata_i[B_FLAG])) |=> flag_q);
   // R5
   removal_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_i |=> flags_q.pd);
   // R6
   absent_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !present_i |=> flags_q.pd);
   // R8
   class_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cls_q) |-> $past(flags_q.pd));
endmodule

// File: rtl/sc_contact_drive.sv
module sc_contact_drive #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_i,
   input  logic req_i,
   input  logic pol_i,
   input  logic rst_lvl_i,
   input  logic clk_src_i,
   input  logic io_src_i,
   output logic card_clk_o,
   output logic card_io_o,
   output logic card_vcc_o,
   output logic card_rst_o
);
   logic live, clk_d, io_d, vcc_d;

   assign live  = ~pd_i;
   assign clk_d = live & clk_src_i;
   assign io_d  = live & io_src_i;
   assign vcc_d = ~((req_i & live) ^ pol_i);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               card_clk_o <= 1'b0;
               card_io_o  <= 1'b0;
               card_vcc_o <= 1'b1;
               card_rst_o <= 1'b0;
            end else begin
               card_clk_o <= clk_d;
               card_io_o  <= io_d;
               card_vcc_o <= vcc_d;
               card_rst_o <= rst_lvl_i;
            end
         end

         // R4
         pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pd_i |=> (!card_clk_o && !card_io_o));
         // R7
         vcc_off_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_i || !req_i) |=> (card_vcc_o == !$past(pol_i)));
         // R4
         rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pd_i |=> (card_rst_o == $past(rst_lvl_i)));
      end else begin : g_comb
         assign card_clk_o = clk_d;
         assign card_io_o  = io_d;
         assign card_vcc_o = vcc_d;
         assign card_rst_o = rst_lvl_i;
      end
   endgenerate
endmodule

// File: rtl/sc_contact_ctrl.sv
module sc_contact_ctrl
   import sc_contact_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CLASS_W     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic               card_present_i,
   input  logic               clk_src_i,
   input  logic               io_src_i,
   output logic               card_clk_o,
   output logic               card_io_o,
   output logic               card_vcc_o,
   output logic               card_rst_o,
   output logic [CLASS_W-1:0] card_class_o,
   output logic               irq_o
);
   logic       present, evt, fall, flag;
   ctl_flags_t flags;

   sc_presence_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(card_present_i),
      .present_o(present), .evt_o(evt), .fall_o(fall)
   );

   sc_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLASS_W(CLASS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .present_i(present), .evt_i(evt), .fall_i(fall),
      .flags_o(flags), .cls_o(card_class_o), .flag_o(flag), .rdata_o(reg_rdata_o)
   );

   sc_contact_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk(clk), .rst_n(rst_n), .pd_i(flags.pd), .req_i(flags.req),
      .pol_i(flags.pol), .rst_lvl_i(flags.rst_lvl), .clk_src_i(clk_src_i),
      .io_src_i(io_src_i), .card_clk_o(card_clk_o), .card_io_o(card_io_o),
      .card_vcc_o(card_vcc_o), .card_rst_o(card_rst_o)
   );

   assign irq_o = flag & flags.ie;
endmodule

// File: tb/sc_contact_ctrl_bench.sv
module sc_contact_ctrl_bench;
   localparam int ADDR_W = 2, DATA_W = 8, CLASS_W = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic               reg_wr = 1'b0;
   logic [ADDR_W-1:0]  reg_addr = '0;
   logic [DATA_W-1:0]  reg_wdata = '0;
   logic [DATA_W-1:0]  reg_rdata;
   logic               card_present = 1'b0, clk_src = 1'b0, io_src = 1'b0;
   logic               card_clk, card_io, card_vcc, card_rst, irq;
   logic [CLASS_W-1:0] card_class;

   sc_contact_ctrl u_sc_contact_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .card_present_i(card_present), .clk_src_i(clk_src), .io_src_i(io_src),
      .card_clk_o(card_clk), .card_io_o(card_io), .card_vcc_o(card_vcc),
      .card_rst_o(card_rst), .card_class_o(card_class), .irq_o(irq)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   // behavioural model state
   bit q[$];
   bit m_pd, m_pol, m_req, m_ie, m_rst, m_flag;
   int m_cls;
   bit o_clk, o_io, o_vcc, o_rst;
   int lfsr = 32'h1d3;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q = '{0, 0, 0};
         m_pd = 1; m_pol = 0; m_req = 0; m_ie = 0; m_rst = 0; m_flag = 0; m_cls = 0;
         o_clk = 0; o_io = 0; o_vcc = 1; o_rst = 0;
      end else begin
         bit sync_now, evt, fall, on;
         sync_now = q[1];
         evt  = (q[1] != q[0]);
         fall = evt && !sync_now;
         on    = m_req && !m_pd;
         o_clk = m_pd ? 0 : clk_src;
         o_io  = m_pd ? 0 : io_src;
         o_vcc = on ? m_pol : !m_pol;
         o_rst = m_rst;
         if (reg_wr && reg_addr == 0) begin
            if (m_pd) m_cls = (reg_wdata >> 5) & 3;
            m_pol = reg_wdata[1]; m_req = reg_wdata[2];
            m_ie = reg_wdata[3]; m_rst = reg_wdata[4];
            m_pd = reg_wdata[0] || !sync_now;
         end
         if (fall) m_pd = 1;
         if (reg_wr && reg_addr == 1 && reg_wdata[0]) m_flag = 0;
         if (evt) m_flag = 1;
         q.push_back(card_present);
         void'(q.pop_front());
      end
   end

   function automatic int exp_rdata();
      if (reg_addr == 0)
         return m_pd | (m_pol << 1) | (m_req << 2) | (m_ie << 3) | (m_rst << 4) | (m_cls << 5);
      if (reg_addr == 1) return m_flag | (q[1] << 1);
      return 0;
   endfunction

   always @(posedge clk) begin
      #2;
      if (rst_n && !finished) begin
         chk("R4 clock contact", card_clk, o_clk);
         chk("R4 data contact", card_io, o_io);
         chk("R4 reset contact", card_rst, o_rst);
         chk("R7 supply pin", card_vcc, o_vcc);
         chk("R8 class output", card_class, m_cls);
         chk("R3 interrupt", irq, m_flag && m_ie);
         chk("R10 read data", reg_rdata, exp_rdata());
      end
   end

   // card clock and data sources change away from the edge
   always @(negedge clk) begin
      clk_src <= ~clk_src;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8000_0057 : 0);
      io_src <= lfsr[0];
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pres(bit v);
      @(negedge clk);
      card_present = v;
   endtask

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(posedge clk); #3;
      // R9 reset state
      chk("R9 ctrl after reset", reg_rdata, 1);
      chk("R9 supply pin after reset", card_vcc, 1);
      chk("R9 irq after reset", irq, 0);
      wr(0, 8'h05);                 // request supply, stay powered down
      set_pres(1); idle(5);         // R1 insertion event
      reg_addr = 1; idle(2);
      wr(0, 8'h0D);                 // R3 enable interrupt
      idle(2);
      wr(1, 8'h00); idle(2);        // R2 write 0 keeps flag
      wr(1, 8'h01); idle(2);        // R2 clear
      wr(0, 8'h0C); idle(6);        // R4 power up, active-low supply
      wr(0, 8'h0E); idle(4);        // R7 polarity high
      wr(0, 8'h6E); idle(2);        // R8 ignored while powered
      wr(0, 8'h0F);
      wr(0, 8'h6F);                 // R8 accepted while powered down
      wr(0, 8'h7F); idle(3);        // R4 reset contact while powered down
      wr(0, 8'h6E); idle(3);
      set_pres(0); idle(6);         // R5 removal forces power-down
      wr(0, 8'h6E); idle(3);        // R6 clear refused while absent
      set_pres(1); set_pres(0); set_pres(1); idle(8);  // R1 rapid toggles
      wr(0, 8'h0A); idle(3);
      wr(1, 8'h01); idle(3);
      reg_addr = 2; idle(2);
      finish_run();
   end
endmodule